// File: doc/BRIEF.md
# Parallel Video to Stream Bridge

This block takes pixels from a parallel video port: one colour word each for red, green and blue, a data-enable strobe and a vertical sync. It turns them into a ready/valid video stream. Each active pixel is packed into a single data word and written into a small first-word-fall-through queue, together with two framing markers. The first marker flags the first pixel of a frame. The second flags the last pixel of a line. The downstream consumer drains the queue at its own pace through the ready signal, and a fill count shows how many words are waiting.

The bridge takes no pixels until it has seen the start of a frame. From then on the stream always opens with a frame-start word. Line ends come from the data-enable strobe: a pixel is held for one clock, so the bridge knows whether the strobe drops after it before that pixel is written. If the queue is full when a pixel is due, the bridge raises a sticky overflow flag. It then ignores the rest of that frame and locks on again at the next vertical sync. The bridge is held in reset until the clock source reports lock and the external reset is released. Both the pixel port and the stream side run on the one clock.

Top module: `vid2stream_bridge`

## Requirements
- R1: The data word carries green in bits [W-1:0], blue in bits [2W-1:W] and red in bits [3W-1:2W], where W is the per-colour width parameter (8 by default, giving a 24-bit word).
- R2: The user marker (`m_tuser`) is high on exactly the first pixel taken after each rising edge of `vid_vsync`, and low on every other word.
- R3: The last marker (`m_tlast`) is high on exactly those pixels whose next clock has `vid_de` low; a one-pixel line carries both markers.
- R4: A word leaves only on a clock edge where `m_tvalid` and `m_tready` are both high; while `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tuser` and `m_tlast` hold their values.
- R5: Only clocks with `vid_de` high produce words, and words leave in arrival order with their markers, whatever the pattern on `m_tready`.
- R6: `fill_count` equals the number of words queued; a pixel presented before clock edge n makes `m_tvalid` high after edge n+1 and not before.
- R7: After reset, pixels are discarded until the first rising edge of `vid_vsync`, so the first word sent carries the user marker.
- R8: While `rst_n` or `clk_locked` is low, the internal reset is applied one clock later; in reset, `m_tvalid`, `fill_count` and `overflow` read 0.
- R9: A pixel due for writing while the queue is full sets `overflow`, which stays high until reset. That pixel and every later pixel of the frame are dropped, and words already queued are still delivered. Capture resumes at the next rising edge of `vid_vsync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and stream clock |
| rst_n | input | 1 | External synchronous reset, active low |
| clk_locked | input | 1 | Clock source lock indication; low keeps the block in reset |
| vid_de | input | 1 | Active-pixel strobe |
| vid_vsync | input | 1 | Vertical sync, active high; rising edge marks a frame start |
| vid_red | input | COMP_W | Red component |
| vid_green | input | COMP_W | Green component |
| vid_blue | input | COMP_W | Blue component |
| m_tdata | output | 3*COMP_W | Packed pixel word |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Consumer ready |
| m_tuser | output | 1 | First pixel of frame marker |
| m_tlast | output | 1 | Last pixel of line marker |
| fill_count | output | FIFO_AW+1 | Words currently queued |
| overflow | output | 1 | Sticky queue overflow flag |

## Verification
Random frames vary the line length from one to ten pixels, the blanking gap and the number of lines, with the ready line high about 85 percent of the time. One-pixel lines show whether both markers can sit on the same word. Random stalls show whether markers stay attached to their pixels and whether the held word keeps still. Directed runs cover the rest. Lines with no vertical sync before them check lock-on. A fully stalled line checks the fill count and the two-clock latency. A stalled 20-pixel line checks overflow, the drop until the next sync and the recovery. Lines sent while the clock source reports no lock check reset gating.

// File: rtl/vsb_pkg.sv
// Shared types for the parallel video to stream bridge.
package vsb_pkg;

    // Framing markers carried alongside every queued pixel.
    typedef struct packed {
        logic sof;  // first pixel of a frame
        logic eol;  // last pixel of a line
    } vsb_mark_t;

    localparam int MARK_W = $bits(vsb_mark_t);

endpackage

// File: rtl/vsb_reset_gate.sv
// Combines the external reset with the clock-lock indication.
// Assumes both inputs are synchronous to clk; output is registered, active low.
module vsb_reset_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_locked,
    output logic rst_int_n
);

    // Hold internal reset until both lock and external release are present.
    always_ff @(posedge clk) begin
        rst_int_n <= rst_n & clk_locked;
    end

    AST_LOCK_GATES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_locked |=> !rst_int_n); // R8

endmodule

// File: rtl/vsb_framer.sv
// Captures active pixels, packs them and attaches frame/line markers.
// Assumes vsync rises during vertical blanking (vid_de low). A pixel is held
// one clock so that the de level of the next clock decides its line-end marker.
module vsb_framer #(
    parameter  int COMP_W = 8,
    localparam int PIX_W  = 3 * COMP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_de,
    input  logic                in_vsync,
    input  logic [COMP_W-1:0]   in_red,
    input  logic [COMP_W-1:0]   in_green,
    input  logic [COMP_W-1:0]   in_blue,
    input  logic                fifo_full,
    output logic                wr_req,
    output vsb_pkg::vsb_mark_t  wr_mark,
    output logic [PIX_W-1:0]    wr_data,
    output logic                ovf
);

    logic              vs_q;
    logic              locked;
    logic              sof_pend;
    logic              hold_vld;
    logic              hold_sof;
    logic [PIX_W-1:0]  hold_data;
    logic              vs_rise;
    logic              take;
    logic              drop;

    assign vs_rise = in_vsync & ~vs_q;
    assign take    = in_de & locked;
    assign drop    = hold_vld & fifo_full;

    // Present the held pixel for writing; de low now means it closed the line.
    always_comb begin
        wr_req      = hold_vld;
        wr_data     = hold_data;
        wr_mark.sof = hold_sof;
        wr_mark.eol = ~in_de;
    end

    // Lock-on, pixel hold stage and overflow handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q      <= 1'b0;
            locked    <= 1'b0;
            sof_pend  <= 1'b0;
            hold_vld  <= 1'b0;
            hold_sof  <= 1'b0;
            hold_data <= '0;
            ovf       <= 1'b0;
        end else begin
            vs_q <= in_vsync;
            if (drop) begin
                ovf      <= 1'b1;
                locked   <= 1'b0;
                sof_pend <= 1'b0;
                hold_vld <= 1'b0;
            end else begin
                hold_vld <= take;
                if (take) begin
                    hold_data <= {in_red, in_blue, in_green};
                    hold_sof  <= sof_pend;
                    sof_pend  <= 1'b0;
                end
                if (vs_rise) begin
                    locked   <= 1'b1;
                    sof_pend <= 1'b1;
                end
            end
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R9
    AST_DROP_AFTER_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> !wr_req); // R9

endmodule

// File: rtl/vsb_fifo.sv
// First-word-fall-through queue with an occupancy count.
// Assumes a write is refused while full, even when a read happens that clock.
module vsb_fifo #(
    parameter  int DW    = 26,
    parameter  int AW    = 4,
    localparam int DEPTH = 1 << AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_word,
    output logic           full,
    output logic [DW-1:0]  rd_word,
    output logic           rd_valid,
    input  logic           rd_ready,
    output logic [AW:0]    count
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push;
    logic          pop;

    assign full     = (count == (AW+1)'(DEPTH));
    assign rd_valid = (count != '0);
    assign rd_word  = mem[rd_ptr];
    assign push     = wr_en & ~full;
    assign pop      = rd_valid & rd_ready;

    // Storage write port.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_word;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_word))); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(count) == count) || (($past(count) + 1'b1) == count)
                  || ((count + 1'b1) == $past(count)))); // R6

endmodule

// File: rtl/vid2stream_bridge.sv
// Top level: parallel video in, ready/valid video stream out, one clock.
// Assumes pixel port and stream consumer share clk.
module vid2stream_bridge #(
    parameter  int COMP_W  = 8,
    parameter  int FIFO_AW = 4,
    localparam int PIX_W   = 3 * COMP_W,
    localparam int ENTRY_W = PIX_W + vsb_pkg::MARK_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_locked,
    input  logic                vid_de,
    input  logic                vid_vsync,
    input  logic [COMP_W-1:0]   vid_red,
    input  logic [COMP_W-1:0]   vid_green,
    input  logic [COMP_W-1:0]   vid_blue,
    output logic [PIX_W-1:0]    m_tdata,
    output logic                m_tvalid,
    input  logic                m_tready,
    output logic                m_tuser,
    output logic                m_tlast,
    output logic [FIFO_AW:0]    fill_count,
    output logic                overflow
);

    logic               rst_int_n;
    logic               wr_req;
    logic               fifo_full;
    vsb_pkg::vsb_mark_t wr_mark;
    logic [PIX_W-1:0]   wr_data;
    logic [ENTRY_W-1:0] rd_word;
    logic               sent_q;

    vsb_reset_gate u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_locked (clk_locked),
        .rst_int_n  (rst_int_n)
    );

    vsb_framer #(.COMP_W(COMP_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .in_de     (vid_de),
        .in_vsync  (vid_vsync),
        .in_red    (vid_red),
        .in_green  (vid_green),
        .in_blue   (vid_blue),
        .fifo_full (fifo_full),
        .wr_req    (wr_req),
        .wr_mark   (wr_mark),
        .wr_data   (wr_data),
        .ovf       (overflow)
    );

    vsb_fifo #(.DW(ENTRY_W), .AW(FIFO_AW)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .wr_en    (wr_req),
        .wr_word  ({wr_mark, wr_data}),
        .full     (fifo_full),
        .rd_word  (rd_word),
        .rd_valid (m_tvalid),
        .rd_ready (m_tready),
        .count    (fill_count)
    );

    assign {m_tuser, m_tlast, m_tdata} = rd_word;

    // Tracks whether any word has left since reset (for the lock-on check).
    always_ff @(posedge clk) begin
        if (!rst_int_n)                sent_q <= 1'b0;
        else if (m_tvalid && m_tready) sent_q <= 1'b1;
    end

    AST_FIRST_WORD_SOF: assert property (@(posedge clk) disable iff (!rst_int_n)
        (m_tvalid && !sent_q) |-> m_tuser); // R7

endmodule

// File: tb/vid2stream_bridge_tb.sv
`timescale 1ns/1ps
module vid2stream_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n, clk_locked, vid_de, vid_vsync, m_tready;
    logic [7:0]  vid_red, vid_green, vid_blue;
    logic [23:0] m_tdata;
    logic        m_tvalid, m_tuser, m_tlast, overflow;
    logic [4:0]  fill_count;

    int          total = 0;
    int          bad   = 0;
    int          rdy_pct = 100;
    bit          sof_next = 1'b0;
    bit          prev_stall = 1'b0;
    logic [25:0] prev_word;
    logic [25:0] exp_q[$];
    bit          done = 1'b0;

    always #10 clk = ~clk;

    vid2stream_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .clk_locked(clk_locked),
        .vid_de(vid_de), .vid_vsync(vid_vsync),
        .vid_red(vid_red), .vid_green(vid_green), .vid_blue(vid_blue),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tuser(m_tuser), .m_tlast(m_tlast),
        .fill_count(fill_count), .overflow(overflow)
    );

    function automatic logic [23:0] pack_px(logic [7:0] r, logic [7:0] g, logic [7:0] b);
        return {r, b, g};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // One clock: drive inputs at the falling edge, then check the stream side.
    task automatic cyc(input logic de, input logic vs, input logic [7:0] r, g, b);
        @(negedge clk);
        vid_de = de; vid_vsync = vs; vid_red = r; vid_green = g; vid_blue = b;
        m_tready = (int'($urandom % 100) < rdy_pct);
        #1;
        if (prev_stall)
            chk(m_tvalid && ({m_tuser, m_tlast, m_tdata} == prev_word), "R4 stall hold",
                {6'd0, m_tuser, m_tlast, m_tdata}, {6'd0, prev_word});
        prev_stall = m_tvalid && !m_tready;
        prev_word  = {m_tuser, m_tlast, m_tdata};
        if (m_tvalid && m_tready) begin
            if (exp_q.size() == 0) chk(1'b0, "R5 unexpected word", {6'd0, prev_word}, 0);
            else begin
                logic [25:0] e = exp_q.pop_front();
                chk(prev_word == e, "R1/R2/R3/R5 word", {6'd0, prev_word}, {6'd0, e});
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'd0, 8'd0, 8'd0);
    endtask

    task automatic vsync_pulse(input bit rec);
        if (rec) sof_next = 1'b1;
        cyc(1'b0, 1'b1, 8'd0, 8'd0, 8'd0);
        cyc(1'b0, 1'b1, 8'd0, 8'd0, 8'd0);
        idle(2);
    endtask

    task automatic line(input int len, input int blank, input bit rec);
        for (int i = 0; i < len; i++) begin
            logic [7:0] r = 8'($urandom), g = 8'($urandom), b = 8'($urandom);
            if (rec) begin
                exp_q.push_back({sof_next, (i == len - 1), pack_px(r, g, b)});
                sof_next = 1'b0;
            end
            cyc(1'b1, 1'b0, r, g, b);
        end
        idle(blank);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; clk_locked = 0; vid_de = 0; vid_vsync = 0;
        vid_red = 0; vid_green = 0; vid_blue = 0; m_tready = 0;
        idle(3);
        // R8: reset state
        chk(!m_tvalid && fill_count == 0 && !overflow, "R8 reset state",
            {m_tvalid, fill_count, overflow}, 0);
        // R8: external reset released, clock not locked: still held
        rst_n = 1;
        vsync_pulse(1'b0);
        line(6, 3, 1'b0);
        chk(!m_tvalid && fill_count == 0, "R8 no lock keeps reset", {m_tvalid, fill_count}, 0);
        // R7: locked, but no frame start yet: pixels discarded
        clk_locked = 1;
        idle(2);
        line(6, 3, 1'b0);
        line(4, 3, 1'b0);
        chk(!m_tvalid && fill_count == 0, "R7 pre-lock discard", {m_tvalid, fill_count}, 0);
        // R6: latency and fill count under full stall
        rdy_pct = 0;
        vsync_pulse(1'b1);
        for (int i = 0; i < 5; i++) begin
            logic [7:0] r = 8'($urandom), g = 8'($urandom), b = 8'($urandom);
            exp_q.push_back({(i == 0), (i == 4), pack_px(r, g, b)});
            cyc(1'b1, 1'b0, r, g, b);
            if (i == 1) chk(!m_tvalid, "R6 not valid after one edge", m_tvalid, 0);
            if (i == 2) chk(m_tvalid && m_tuser, "R6/R2 valid after two edges", {m_tvalid, m_tuser}, 3);
        end
        sof_next = 1'b0;
        idle(3);
        chk(fill_count == 5, "R6 fill count", fill_count, 5);
        rdy_pct = 100;
        idle(8);
        chk(fill_count == 0 && exp_q.size() == 0, "R6 drained", fill_count, 0);
        // R2/R3/R4/R5: random frames with random backpressure
        rdy_pct = 85;
        for (int f = 0; f < 8; f++) begin
            int nl = 2 + int'($urandom % 3);
            vsync_pulse(1'b1);
            for (int l = 0; l < nl; l++)
                line(1 + int'($urandom % 10), 4 + int'($urandom % 4), 1'b1);
        end
        line(1, 4, 1'b1);
        rdy_pct = 100;
        idle(24);
        chk(exp_q.size() == 0, "R5 all words delivered", exp_q.size(), 0);
        chk(!overflow, "R9 no false overflow", overflow, 0);
        // R9: overflow while stalled
        rdy_pct = 0;
        vsync_pulse(1'b1);
        line(20, 3, 1'b1);
        for (int i = 0; i < 4; i++) void'(exp_q.pop_back());
        chk(overflow, "R9 overflow set", overflow, 1);
        chk(fill_count == 16, "R9 queue full", fill_count, 16);
        line(6, 3, 1'b0);
        chk(fill_count == 16, "R9 rest of frame dropped", fill_count, 16);
        rdy_pct = 100;
        idle(24);
        chk(exp_q.size() == 0 && fill_count == 0, "R9 queued words delivered", fill_count, 0);
        line(5, 3, 1'b0);
        chk(!m_tvalid, "R9 still dropping before vsync", m_tvalid, 0);
        vsync_pulse(1'b1);
        line(4, 3, 1'b1);
        line(3, 3, 1'b1);
        idle(10);
        chk(exp_q.size() == 0, "R9 recovery after vsync", exp_q.size(), 0);
        chk(overflow, "R9 overflow sticky", overflow, 1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule